// File: doc/BRIEF.md
# Half-Rate Read Latency Timer

This block times the read-enable pulse of a memory device's output path. A read command is sampled on the full-rate clock. Exactly the programmed latency later, counted in full-rate cycles, the block raises a read-enable pulse one cycle wide. The latency is written once after reset through a load strobe. It stays fixed while reads are in flight.

Most of the counting runs on a half-rate clock enable that toggles every full-rate cycle. Each read command takes a free slot from a small pool of half-rate counters. The slot records which half-rate phase the command arrived in. When a slot expires, a short full-rate tail adds the remaining zero to two cycles. That tail comes in two variants: one for even latencies and one for odd latencies. The parity of the programmed latency picks the variant. Several reads can be in flight at the same time, provided consecutive commands are at least four cycles apart.

Top module: `cas_lat_top`

## Requirements
- R1: A read command sampled high in cycle t makes rd_en high in cycle t+L, where L is the programmed latency. This holds for every L from 5 to 11.
- R2: rd_en is high for exactly one full-rate cycle per read command.
- R3: A loaded latency value below 5 is taken as 5. A loaded value above 11 is taken as 11. lat_val is a 4-bit unsigned value.
- R4: After reset the latency is 5. A new latency takes effect only on a cycle with lat_load high. While lat_load is low, lat_val has no effect.
- R5: Read commands spaced four or more cycles apart each produce their own pulse at their own command cycle plus L.
- R6: rd_en is low during reset. It is also low in every cycle that no read command accounts for.
- R7: The timing in R1 is the same whether the command arrives in an even or an odd cycle counted from reset. In other words, it does not depend on the half-rate phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Read command, sampled once per cycle |
| lat_load | input | 1 | Strobe that loads lat_val as the new latency |
| lat_val | input | 4 | Requested latency in full-rate cycles (clamped to 5..11) |
| rd_en | output | 1 | Read-enable pulse, one cycle wide, L cycles after the command |

## Verification
The checker assumes that no two read commands come within three cycles of each other. It also assumes that the latency is not reloaded while a read is pending. So it checks exact timing only once the history left over from the last load has aged out. The stimulus issues commands in controlled bursts with gaps of four or more cycles. Before each new load it waits until the last pulse has been checked, and after each load it waits fourteen idle cycles. It issues every command on a chosen cycle parity, so that each latency is tried in both half-rate phases.

// File: rtl/cas_lat_pkg.sv
package cas_lat_pkg;
    localparam int LAT_W   = 4;
    localparam int LAT_MIN = 5;
    localparam int LAT_MAX = 11;
    localparam int CNT_W   = $clog2(LAT_MAX / 2 + 1);
    localparam int TAIL_W  = 4;

    typedef struct packed {
        logic             vld;
        logic             ph;
        logic [CNT_W-1:0] cnt;
    } slot_t;
endpackage

// File: rtl/cas_lat_cfg.sv
module cas_lat_cfg
    import cas_lat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_load,
    input  logic [LAT_W-1:0] lat_val,
    output logic [LAT_W-1:0] lat_q,
    output logic [CNT_W-1:0] half_ld,
    output logic             odd
);
    logic [LAT_W-1:0] lat_d;
    logic [LAT_W-1:0] half;

    always_comb begin
        lat_d = lat_q;
        if (lat_load) begin
            if (lat_val < LAT_W'(LAT_MIN))      lat_d = LAT_W'(LAT_MIN);
            else if (lat_val > LAT_W'(LAT_MAX)) lat_d = LAT_W'(LAT_MAX);
            else                                lat_d = lat_val;
        end
        half    = lat_q >> 1;
        half_ld = half[CNT_W-1:0] - CNT_W'(1);
        odd     = lat_q[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= LAT_W'(LAT_MIN);
        else        lat_q <= lat_d;
    end
endmodule

// File: rtl/cas_lat_pool.sv
module cas_lat_pool
    import cas_lat_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph,
    input  logic             cmd,
    input  logic [CNT_W-1:0] half_ld,
    output logic             fire,
    output logic             fire_ph
);
    slot_t [NSLOT-1:0] slot_q;
    slot_t [NSLOT-1:0] slot_d;
    logic              taken;

    always_comb begin
        slot_d  = slot_q;
        fire    = 1'b0;
        fire_ph = 1'b0;
        taken   = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_q[s].vld && ph) begin
                if (slot_q[s].cnt == CNT_W'(1)) begin
                    fire          = 1'b1;
                    fire_ph       = fire_ph | slot_q[s].ph;
                    slot_d[s].vld = 1'b0;
                end else begin
                    slot_d[s].cnt = slot_q[s].cnt - CNT_W'(1);
                end
            end
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (cmd && !taken && !slot_q[s].vld) begin
                slot_d[s].vld = 1'b1;
                slot_d[s].ph  = ph;
                slot_d[s].cnt = half_ld;
                taken         = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end
endmodule

// File: rtl/cas_lat_tail.sv
module cas_lat_tail
    import cas_lat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic fire_ph,
    input  logic odd,
    output logic rd_en
);
    logic [TAIL_W-1:0] inj [2];
    logic [TAIL_W-1:0] sh_q;
    logic [TAIL_W-1:0] sh_d;

    // Variant g = 0 serves even latencies, g = 1 odd ones (one extra stage).
    for (genvar g = 0; g < 2; g++) begin : g_variant
        localparam int POS_EARLY = 1 + g;
        localparam int POS_LATE  = 2 + g;
        assign inj[g] = !fire   ? '0 :
                        fire_ph ? TAIL_W'(1) << POS_EARLY :
                                  TAIL_W'(1) << POS_LATE;
    end

    always_comb begin
        sh_d = (sh_q >> 1) | inj[odd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rd_en = sh_q[0];
endmodule

// File: rtl/cas_lat_top.sv
module cas_lat_top
    import cas_lat_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic             lat_load,
    input  logic [LAT_W-1:0] lat_val,
    output logic             rd_en
);
    typedef struct packed {
        logic ph;
    } top_st_t;

    top_st_t          st_q;
    top_st_t          st_d;
    logic [LAT_W-1:0] lat_q;
    logic [CNT_W-1:0] half_ld;
    logic             odd;
    logic             fire;
    logic             fire_ph;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cas_lat_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_load (lat_load),
        .lat_val  (lat_val),
        .lat_q    (lat_q),
        .half_ld  (half_ld),
        .odd      (odd)
    );

    cas_lat_pool #(.NSLOT(NSLOT)) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (st_q.ph),
        .cmd     (rd_cmd),
        .half_ld (half_ld),
        .fire    (fire),
        .fire_ph (fire_ph)
    );

    cas_lat_tail u_tail (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .fire_ph (fire_ph),
        .odd     (odd),
        .rd_en   (rd_en)
    );
endmodule

// File: rtl/cas_lat_chk.sv
module cas_lat_chk
    import cas_lat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_cmd,
    input logic             lat_load,
    input logic [LAT_W-1:0] lat_q,
    input logic             rd_en
);
    logic [15:0] hist_q;
    logic [4:0]  age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            age_q  <= 5'd16;
        end else begin
            hist_q <= {hist_q[14:0], rd_cmd};
            if (lat_load)            age_q <= '0;
            else if (age_q != 5'd31) age_q <= age_q + 5'd1;
        end
    end

    // R1 / R7: pulse matches the command L cycles back, whatever the phase
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 5'd12) |-> (rd_en == hist_q[lat_q - 4'd1]));

    p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_lat_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q >= LAT_W'(LAT_MIN)) && (lat_q <= LAT_W'(LAT_MAX)));

    p_lat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_load |=> $stable(lat_q));

    // R5: input rule, commands at least four cycles apart
    p_cmd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |-> (hist_q[2:0] == 3'b000));
endmodule

bind cas_lat_top cas_lat_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .lat_load (lat_load),
    .lat_q    (lat_q),
    .rd_en    (rd_en)
);

// File: tb/cas_lat_top_tb_top.sv
module cas_lat_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cmd = 1'b0;
    logic       lat_load = 1'b0;
    logic [3:0] lat_val = 4'd0;
    logic       rd_en;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cas_lat_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .lat_load (lat_load),
        .lat_val  (lat_val),
        .rd_en    (rd_en)
    );

    task automatic check(input string req, input logic act, input logic exp, input int at);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_en=%0b expected %0b at offset %0d", req, act, exp, at);
        end
    endtask

    task automatic load(input logic [3:0] v);
        @(negedge clk);
        lat_load = 1'b1;
        lat_val  = v;
        @(negedge clk);
        lat_load = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    // Issue cnt commands gap cycles apart, starting in a cycle of parity par,
    // checking rd_en in every cycle until L+3 after the last command.
    task automatic burst(input string req, input int lat, input int gap,
                         input int cnt, input int par);
        int span;
        span = (cnt - 1) * gap + lat + 3;
        @(negedge clk);
        while ((cyc % 2) != par) @(negedge clk);
        for (int i = 0; i <= span; i++) begin
            logic exp;
            if (i > 0) @(negedge clk);
            exp = (i >= lat) && (((i - lat) % gap) == 0) && (((i - lat) / gap) < cnt);
            check(req, rd_en, exp, i);
            rd_cmd = ((i % gap) == 0) && ((i / gap) < cnt);
        end
        rd_cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset", rd_en, 1'b0, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 idle", rd_en, 1'b0, 0);

        // R4: default latency 5 after reset
        burst("R4 default", 5, 4, 1, 0);

        // R1 / R7: every latency in both half-rate phases
        for (int l = 5; l <= 11; l++) begin
            load(4'(l));
            burst("R1 even-phase", l, 4, 1, 0);
            burst("R7 odd-phase", l, 4, 1, 1);
        end

        // R3: clamping at both ends
        load(4'd2);
        burst("R3 low clamp", 5, 4, 1, 1);
        load(4'd0);
        burst("R3 zero clamp", 5, 4, 1, 0);
        load(4'd15);
        burst("R3 high clamp", 11, 4, 1, 0);
        load(4'd12);
        burst("R3 just above", 11, 4, 1, 1);

        // R4: lat_val ignored without the strobe
        load(4'd9);
        lat_val = 4'd6;
        repeat (3) @(negedge clk);
        burst("R4 hold", 9, 4, 1, 0);

        // R5 / R2: back-to-back commands
        load(4'd11);
        burst("R5 gap4 L11", 11, 4, 4, 0);
        burst("R5 gap4 L11 odd", 11, 4, 4, 1);
        load(4'd8);
        burst("R5 gap5 L8", 8, 5, 4, 1);
        burst("R2 gap7 L8", 8, 7, 3, 0);
        load(4'd5);
        burst("R5 gap4 L5", 5, 4, 5, 1);
        load(4'd6);
        burst("R5 gap6 L6", 6, 6, 3, 0);

        repeat (20) begin
            @(negedge clk);
            check("R6 quiet", rd_en, 1'b0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule